// File: doc/BRIEF.md
# Arithmetic Unit with Registered Condition Flags

This block pairs a combinational add/subtract datapath with a small status register that holds five condition bits. Two 16-bit operands arrive: the accumulator value on `x_in` and the second operand on `y_in`. A 2-bit operation code selects what the datapath does. The arithmetic result appears on `res_out` in the same cycle. The condition bits are computed from the current operands and operation, and they are captured only when the write strobe is high at a rising clock edge.

Branch logic reads the stored status through a read strobe and a 2-bit condition selector. The block returns one bit that says whether the chosen jump condition holds. The magnitude flags do not come from the subtractor. A separate unsigned comparator produces them, so compare, add and subtract all leave a valid greater/equal/less triple. A compare produces no new result: on the two non-arithmetic codes the result port passes the accumulator operand through unchanged. Every pin is a plain control or status pin. No stream interface is involved, so there is no back-pressure.

Top module: `alu_flag_unit`

## Requirements
- R1: With `op_sel` = 2'b10 (add), `res_out` equals (`x_in` + `y_in`) modulo 2^16 in the same cycle.
- R2: With `op_sel` = 2'b11 (subtract), `res_out` equals (`x_in` - `y_in`) modulo 2^16 in the same cycle.
- R3: With `op_sel` = 2'b00 (no operation) or 2'b01 (compare), `res_out` equals `x_in`.
- R4: `flags_q` has this bit order: bit 4 negative, bit 3 carry, bit 2 greater, bit 1 equal, bit 0 less. On a write, bits 2..0 capture `x_in` > `y_in`, `x_in` == `y_in` and `x_in` < `y_in`, comparing the operands as unsigned values. Exactly one of these three bits is set after any write.
- R5: On a write, the negative bit captures bit 15 of `res_out` for the operation then applied.
- R6: On a write, the carry bit captures the following, by operation:
  - add: the carry-out of the 16-bit sum.
  - subtract: the borrow, which is set when `x_in` < `y_in` unsigned.
  - no operation and compare: 0.
- R7: `flags_q` loads only at a rising clock edge where `flag_we` is 1. At every other edge it keeps its value.
- R8: While `rst_n` is low, `flags_q` is 5'b00000. Reset is asynchronous and active low.
- R9: `branch_taken` is 0 while `flag_rd` is 0. While `flag_rd` is 1, `branch_taken` is the stored bit picked by `cond_sel`: 2'b00 negative, 2'b01 greater, 2'b10 equal, 2'b11 less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 16 | Accumulator operand |
| y_in | input | 16 | Second operand |
| op_sel | input | 2 | 00 none, 01 compare, 10 add, 11 subtract |
| res_out | output | 16 | Combinational result |
| flag_we | input | 1 | Capture condition bits at the next rising edge |
| flag_rd | input | 1 | Enable the branch condition output |
| cond_sel | input | 2 | Condition select: 00 N, 01 G, 10 E, 11 L |
| flags_q | output | 5 | Stored {N, C, G, E, L} |
| branch_taken | output | 1 | Selected stored condition, gated by `flag_rd` |

## Verification
Two situations are the hardest to reach from the ports. The first is the boundary where carry and the magnitude bits disagree with a naive signed reading. Examples are an add that wraps exactly to zero (0xFFFF + 0x0001), a subtract with `x_in` just below `y_in`, and operands whose top bits differ, where an unsigned compare and a signed compare give opposite answers. The second is a change of operands while the write strobe is low: the stored bits must then keep the old compare outcome even though the live comparator has already moved. The stimulus uses directed vectors at these edges first. It then runs a long pseudo-random phase in which the write strobe, the read strobe and the selector toggle independently, so stale stored values are read back through every condition.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CMP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_NEG  = 2'b00,
    SEL_GT   = 2'b01,
    SEL_EQ   = 2'b10,
    SEL_LT   = 2'b11
  } cond_sel_e;

  localparam int unsigned FLAG_W   = 5;
  localparam int unsigned FIDX_NEG = 4;
  localparam int unsigned FIDX_CRY = 3;
  localparam int unsigned FIDX_GT  = 2;
  localparam int unsigned FIDX_EQ  = 1;
  localparam int unsigned FIDX_LT  = 0;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flag_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [1:0]        op,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] next_flags
);
  localparam int unsigned MSB = DW - 1;

  logic [DW:0]   sum_ext;
  logic [DW:0]   diff_ext;
  logic          mag_gt, mag_eq, mag_lt;
  logic          carry_bit;

  // adder and subtractor run in parallel
  assign sum_ext  = {1'b0, opa} + {1'b0, opb};
  assign diff_ext = {1'b0, opa} - {1'b0, opb};

  // dedicated unsigned magnitude comparator
  assign mag_gt = (opa > opb);
  assign mag_eq = (opa == opb);
  assign mag_lt = (opa < opb);

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD: begin
        result    = sum_ext[DW-1:0];
        carry_bit = sum_ext[DW];
      end
      OP_SUB: begin
        result    = diff_ext[DW-1:0];
        carry_bit = diff_ext[DW];
      end
      default: begin
        result    = opa;
        carry_bit = 1'b0;
      end
    endcase
  end

  always_comb begin
    next_flags           = '0;
    next_flags[FIDX_NEG] = result[MSB];
    next_flags[FIDX_CRY] = carry_bit;
    next_flags[FIDX_GT]  = mag_gt;
    next_flags[FIDX_EQ]  = mag_eq;
    next_flags[FIDX_LT]  = mag_lt;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_W-1:0] d,
  input  logic              rd,
  input  logic [1:0]        sel,
  output logic [FLAG_W-1:0] q,
  output logic              taken
);
  logic picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  always_comb begin
    unique case (cond_sel_e'(sel))
      SEL_NEG: picked = q[FIDX_NEG];
      SEL_GT:  picked = q[FIDX_GT];
      SEL_EQ:  picked = q[FIDX_EQ];
      default: picked = q[FIDX_LT];
    endcase
  end

  assign taken = rd & picked;

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  // R4
  one_magnitude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($countones(q[FIDX_GT:FIDX_LT]) == 1));

  // R9
  no_read_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> !taken);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic [1:0]    op_sel,
  output logic [DW-1:0] res_out,
  input  logic          flag_we,
  input  logic          flag_rd,
  input  logic [1:0]    cond_sel,
  output logic [4:0]    flags_q,
  output logic          branch_taken
);
  logic [FLAG_W-1:0] nxt;

  alu_datapath #(.DW(DW)) u_dp (
    .opa(x_in), .opb(y_in), .op(op_sel),
    .result(res_out), .next_flags(nxt)
  );

  alu_flag_reg u_fr (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(nxt),
    .rd(flag_rd), .sel(cond_sel), .q(flags_q), .taken(branch_taken)
  );

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_NONE || op_sel == OP_CMP) |-> (res_out == x_in));

  // R6
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel == OP_SUB) |=>
      (flags_q[FIDX_CRY] == ($past(x_in) < $past(y_in))));

  // R5
  neg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_q[FIDX_NEG] == $past(res_out[DW-1])));
endmodule

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic [1:0]  op_sel = '0, cond_sel = '0;
  logic        flag_we = 1'b0, flag_rd = 1'b0;
  logic [15:0] res_out;
  logic [4:0]  flags_q;
  logic        branch_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [4:0] mdl_flags = '0;

  always #2.5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .op_sel(op_sel),
    .res_out(res_out), .flag_we(flag_we), .flag_rd(flag_rd),
    .cond_sel(cond_sel), .flags_q(flags_q), .branch_taken(branch_taken)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int x, input int y, input int op);
    if (op == 2) return (x + y) & 32'hFFFF;
    if (op == 3) return (x - y) & 32'hFFFF;
    return x;
  endfunction

  function automatic logic [4:0] exp_flags(input int x, input int y, input int op);
    int r;
    int c;
    r = exp_res(x, y, op);
    c = 0;
    if (op == 2) c = ((x + y) > 65535) ? 1 : 0;
    if (op == 3) c = (x < y) ? 1 : 0;
    return {r[15] == 1'b1, c == 1, x > y, x == y, x < y};
  endfunction

  function automatic int exp_branch(input logic [4:0] f, input int rd, input int sel);
    if (rd == 0) return 0;
    case (sel)
      0: return f[4];
      1: return f[2];
      2: return f[1];
      default: return f[0];
    endcase
  endfunction

  task automatic step(input int x, input int y, input int op, input int we,
                      input int rd, input int sel);
    string tag;
    @(negedge clk);
    x_in = 16'(x); y_in = 16'(y); op_sel = 2'(op);
    flag_we = 1'(we); flag_rd = 1'(rd); cond_sel = 2'(sel);
    #1;
    tag = (op == 2) ? "R1" : (op == 3) ? "R2" : "R3";
    check(tag, res_out, exp_res(x, y, op));
    check("R7 R4 R5 R6 stored flags", flags_q, mdl_flags);
    check("R9", branch_taken, exp_branch(mdl_flags, rd, sel));
    @(posedge clk);
    if (we != 0) mdl_flags = exp_flags(x, y, op);
  endtask

  initial begin
    #1;
    check("R8 reset flags", flags_q, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset flags held", flags_q, 0);
    rst_n = 1'b1;
    // directed boundaries
    step(16'hFFFF, 16'h0001, 2, 1, 0, 0);   // R1 wrap to zero, carry R6
    step(16'h0000, 16'h0001, 3, 1, 1, 3);   // R2 borrow R6
    step(16'h1234, 16'h1234, 1, 1, 1, 0);   // R3 compare equal R4
    step(16'h8000, 16'h7FFF, 0, 1, 1, 2);   // unsigned greater R4
    step(16'h0001, 16'h9000, 2, 0, 1, 1);   // R7 no write
    step(16'h0001, 16'h9000, 3, 0, 1, 3);   // R7 still held
    step(16'h7FFF, 16'h0001, 2, 1, 1, 0);   // R5 negative from sum
    step(16'h0005, 16'h0003, 3, 1, 1, 1);
    step(16'h0005, 16'h0003, 0, 0, 1, 0);
    step(16'h0005, 16'h0003, 0, 0, 1, 1);
    step(16'h0005, 16'h0003, 0, 0, 1, 2);
    step(16'h0005, 16'h0003, 0, 0, 1, 3);
    step(16'h0005, 16'h0003, 0, 0, 0, 1);   // R9 read strobe low
    for (int i = 0; i < 3000; i++) begin
      int rx, ry;
      rx = $urandom_range(0, 65535);
      ry = (i % 7 == 0) ? rx : $urandom_range(0, 65535);
      step(rx, ry, $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 3));
    end
    @(negedge clk);
    check("R7 final", flags_q, mdl_flags);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule